// File: doc/BRIEF.md
# Shared interrupt line aggregator

This block folds the level-sensitive interrupt pins of several functions onto four shared interrupt lines. Every function drives four pins. The block keeps the last level it has accepted for each pin. When an input differs from that stored level, the block treats it as an event. Each event raises or lowers a per-line count of asserted sources. A line is high whenever its count is above zero. Two sources that share a line therefore do not cancel each other, as they could if the block tracked a single flag per line.

Some functions sit on the root bus. Others sit behind one bridge that occupies a slot on the root bus. A pin of a root function is routed to line `(pin + device) mod 4`. A pin of a function behind the bridge is routed twice. The first step uses its device number on the secondary bus. The result of that step is then treated as a pin of the bridge and routed again with the bridge's slot. If several inputs change in the same cycle, a fixed-priority arbiter accepts one of them per clock.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, all pin states and counters are cleared and `irq_out` is 4'b0000.
- R2: Bit `src*4+pin` of `src_lvl` is pin `pin` (0 to 3) of source `src`. Sources 0 to N_ROOT-1 sit on the root bus with device number equal to `src`. Their pins drive line `(pin + src) mod 4`, which is bit `line` of `irq_out`.
- R3: Sources N_ROOT to N_ROOT+N_SUB-1 sit behind the bridge with secondary device number `d = src - N_ROOT`. Their pins drive line `(((pin + d) mod 4) + BRIDGE_SLOT) mod 4`.
- R4: A line is high exactly while at least one accepted asserted pin maps to it. Lowering one of two asserted pins that share a line leaves the line high. Lowering the last one drives the line low.
- R5: A pin held at its stored level causes no update, however long it is held. A pin held high for many cycles counts once, so one falling change clears its contribution.
- R6: At most one pin change is accepted per clock, and the lowest bit index wins. A change is visible on `irq_out` one clock after it is accepted.
- R7: If a pin returns to its stored level before its change has been accepted, the pin has no effect on any line.
- R8: A line counter never decrements below zero and never steps by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_lvl | input | 4*(N_ROOT+N_SUB) | Current levels of all interrupt pins, bit `src*4+pin` |
| irq_out | output | 4 | Shared interrupt lines, one bit per line |

## Verification
The bench attacks line sharing. It raises two sources onto one line and then lowers them one at a time. A design that ORs only the last event would drop the line early. The bench also raises pins in the same cycle and checks the order in which the lines rise. A design with inverted priority, or one that accepts several changes per clock, shows the wrong line first. A pin that glitches back while it is still waiting behind another change must leave its line untouched. A design that latched pending events would raise a phantom line. The bridged sources check the second routing step, which a design that routes them only once would send to the wrong line.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_ROOT      = 4,
  parameter int N_SUB       = 3,
  parameter int BRIDGE_SLOT = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [4*(N_ROOT+N_SUB)-1:0]       src_lvl,
  output logic [3:0]                        irq_out
);
  localparam int NSRC  = N_ROOT + N_SUB;
  localparam int NPINS = 4 * NSRC;
  localparam int CW    = $clog2(NSRC + 1);
  localparam int SW    = $clog2(NPINS);

  function automatic logic [1:0] route(input int idx);
    int s, p, q;
    s = idx / 4;
    p = idx % 4;
    if (s < N_ROOT) q = (p + s) % 4;
    else q = (((p + s - N_ROOT) % 4) + BRIDGE_SLOT) % 4;
    return q[1:0];
  endfunction

  logic [NPINS-1:0]  pin_state;
  logic [NPINS-1:0]  pending;
  logic [CW-1:0]     cnt [4];
  logic [4*CW-1:0]   cnt_flat;
  logic [1:0]        line_tbl [NPINS];
  logic [SW-1:0]     sel;
  logic              hit;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_route
      assign line_tbl[g] = route(g);
    end
    for (g = 0; g < 4; g++) begin : g_line
      assign irq_out[g] = |cnt[g];
      assign cnt_flat[g*CW +: CW] = cnt[g];
    end
  endgenerate

  assign pending = src_lvl ^ pin_state;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        hit = 1'b1;
        sel = SW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_state <= '0;
      for (int l = 0; l < 4; l++) cnt[l] <= '0;
    end else if (hit) begin
      pin_state[sel] <= src_lvl[sel];
      if (src_lvl[sel]) cnt[line_tbl[sel]] <= cnt[line_tbl[sel]] + 1'b1;
      else              cnt[line_tbl[sel]] <= cnt[line_tbl[sel]] - 1'b1;
    end
  end
endmodule

module irq_aggregator_chk #(
  parameter int NPINS = 28,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pins,
  input logic [NPINS-1:0] state,
  input logic [4*CW-1:0]  cnt,
  input logic [3:0]       irq
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (irq == 4'b0000 && state == '0));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == '0) |-> (irq == 4'b0000));

  assert_hold_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (pins == state) |=> $stable(state));

  assert_single_accept_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(state ^ $past(state)) <= 1);

  genvar l;
  generate
    for (l = 0; l < 4; l++) begin : g_cnt
      assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt[l*CW +: CW] == '0) |=> (cnt[l*CW +: CW] <= CW'(1)));
      assert_unit_step_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt[l*CW +: CW] == $past(cnt[l*CW +: CW])) ||
        (cnt[l*CW +: CW] == $past(cnt[l*CW +: CW]) + CW'(1)) ||
        (cnt[l*CW +: CW] == $past(cnt[l*CW +: CW]) - CW'(1)));
    end
  endgenerate
endmodule

bind irq_aggregator irq_aggregator_chk #(.NPINS(NPINS), .CW(CW)) chk (
  .clk(clk), .rst(rst), .pins(src_lvl), .state(pin_state), .cnt(cnt_flat), .irq(irq_out));

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int N_ROOT = 4, N_SUB = 3, BRIDGE_SLOT = 5;
  localparam int NPINS = 4 * (N_ROOT + N_SUB);

  logic clk = 1'b0, rst = 1'b1;
  logic [NPINS-1:0] src_lvl = '0;
  logic [3:0] irq_out;
  int checks = 0, fails = 0;

  irq_aggregator #(.N_ROOT(N_ROOT), .N_SUB(N_SUB), .BRIDGE_SLOT(BRIDGE_SLOT)) uut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .irq_out(irq_out));

  always #10 clk = ~clk;

  bit m_state [NPINS];
  int m_cnt [4];

  function automatic int dest_line(int idx);
    int src = idx / 4;
    int ln = idx % 4;
    int slots[$];
    if (src < N_ROOT) slots.push_back(src);
    else begin
      slots.push_back(src - N_ROOT);
      slots.push_back(BRIDGE_SLOT);
    end
    foreach (slots[k]) ln = (ln + slots[k]) % 4;
    return ln;
  endfunction

  function automatic logic [3:0] model_out();
    logic [3:0] v;
    for (int l = 0; l < 4; l++) v[l] = (m_cnt[l] != 0);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_state[i]) m_state[i] = 1'b0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (src_lvl[i] != m_state[i]) begin
          m_state[i] = src_lvl[i];
          m_cnt[dest_line(i)] += src_lvl[i] ? 1 : -1;
          break;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq_out !== model_out()) begin
        fails++;
        $display("FAIL R4 model compare: irq_out=%b expected=%b", irq_out, model_out());
      end
    end
  end

  task automatic expect_out(string req, logic [3:0] exp);
    checks++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s: irq_out=%b expected=%b", req, irq_out, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    expect_out("R1 during reset", 4'b0000);
    rst = 1'b0;
    tick(1);
    expect_out("R1 after reset", 4'b0000);

    src_lvl[9] = 1'b1; tick(1);
    expect_out("R2 src2 pin1 to line3", 4'b1000);
    src_lvl[9] = 1'b0; tick(1);
    expect_out("R2 release", 4'b0000);

    src_lvl[22] = 1'b1; tick(1);
    expect_out("R3 bridged src5 pin2 to line0", 4'b0001);
    src_lvl[22] = 1'b0; tick(1);
    expect_out("R3 release", 4'b0000);
    src_lvl[26] = 1'b1; tick(1);
    expect_out("R3 bridged src6 pin2 to line1", 4'b0010);
    src_lvl[26] = 1'b0; tick(1);

    src_lvl[0] = 1'b1; src_lvl[7] = 1'b1; tick(2);
    expect_out("R4 shared line both up", 4'b0001);
    src_lvl[0] = 1'b0; tick(2);
    expect_out("R4 one of two dropped", 4'b0001);
    src_lvl[7] = 1'b0; tick(1);
    expect_out("R4 last dropped", 4'b0000);

    src_lvl[1] = 1'b1; src_lvl[2] = 1'b1; tick(1);
    expect_out("R6 lowest index first", 4'b0010);
    tick(1);
    expect_out("R6 second accepted", 4'b0110);
    src_lvl[1] = 1'b0; src_lvl[2] = 1'b0; tick(2);
    expect_out("R6 both released", 4'b0000);

    src_lvl[0] = 1'b1; src_lvl[12] = 1'b1; tick(1);
    src_lvl[12] = 1'b0;
    expect_out("R7 first accepted only", 4'b0001);
    tick(2);
    expect_out("R7 glitched pin ignored", 4'b0001);
    src_lvl[0] = 1'b0; tick(1);
    expect_out("R7 release", 4'b0000);

    src_lvl[9] = 1'b1; tick(6);
    expect_out("R5 held pin", 4'b1000);
    src_lvl[9] = 1'b0; tick(1);
    expect_out("R5 single count cleared", 4'b0000);

    for (int n = 0; n < 400; n++) begin
      src_lvl[$urandom_range(NPINS - 1)] ^= 1'b1;
      if ($urandom_range(3) == 0) src_lvl[$urandom_range(NPINS - 1)] ^= 1'b1;
      tick(1);
    end
    src_lvl = '0;
    tick(NPINS + 2);
    expect_out("R8 drained to zero", 4'b0000);

    rst = 1'b1; tick(1);
    expect_out("R1 reset mid-run", 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule